// File: doc/BRIEF.md
# Framed Message Parser With Address Filter

This block sits behind a byte receiver and turns its stream of bytes into checked, addressed messages. A frame opens with a fixed marker byte. A length byte follows it, then a two-byte destination, a command byte, a variable number of payload bytes and a closing checksum byte. The parser accumulates an additive checksum while the frame arrives and stores the payload in a small buffer. Once the checksum byte has been received, it decides whether the frame is intact and whether this station is the destination.

The destination is compared against three station registers: a 16-bit main identity, an 8-bit short identity and an 8-bit group identity. The top page of the address space is reserved for range-selected comparisons and for two broadcasts, one of which can be masked. If a frame passes both tests, the block pulses an accept flag together with the command byte. It then releases the buffered payload one byte per cycle, in arrival order. A length outside the legal window or a bad checksum raises a one-cycle error pulse. A well-formed frame for another station is dropped without any output. The station registers are loaded through a simple write port by the logic that executes commands.

Top module: `msg_frame_filter`

## Requirements
- R1: While waiting for a frame, every byte other than 0xA5 is discarded: it produces no accept, no error and no data, and a frame that follows it is parsed normally.
- R2: The byte after 0xA5 gives the number of bytes that remain in the frame, checksum included. A value below 4 or above 22 produces one frame_err pulse and returns the parser to waiting. The value 4 means a frame with no payload.
- R3: The checksum byte must equal the sum modulo 256 of the length byte, both address bytes, the command byte and every payload byte. On a mismatch there is one frame_err pulse and no accept, command or data output.
- R4: A destination from 0x0000 through 0xFBFF is accepted only when it equals the 16-bit main register. The address is sent high byte first.
- R5: A destination 0xFCxx is accepted when xx equals the short register. A destination 0xFDxx is accepted when xx equals the group register.
- R6: A destination 0xFExx is accepted when xx equals the upper byte of the main register.
- R7: 0xFFFF is always accepted. 0xFFFE is accepted only while bcast_mask is 0. Every other 0xFFxx destination is never accepted.
- R8: After reset, the main register holds 0xFF00 and the short and group registers hold 0x00. As a result, 0xFEFF, 0xFC00 and 0xFD00 reach an unprogrammed station.
- R9: A frame with a correct checksum but a destination that does not match produces neither accept nor error nor data.
- R10: On acceptance, msg_accept and cmd_valid are high for exactly one cycle, starting the cycle after the checksum byte is taken, with cmd_o holding the command. The payload bytes follow on data_o, one per cycle with data_valid, in arrival order, length-4 bytes in all. No payload byte leaves before acceptance.
- R11: When addr_wr_en is high, addr_wr_sel picks the register to load from addr_wr_data: 0 loads all 16 bits into main, 1 loads the low 8 bits into short, 2 loads the low 8 bits into group, and 3 changes nothing.
- R12: frame_err rises in the cycle after the offending length or checksum byte is taken and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| bcast_mask | input | 1 | When 1, the maskable broadcast 0xFFFE is rejected |
| addr_wr_en | input | 1 | Load strobe for a station register |
| addr_wr_sel | input | 2 | Register select: 0 main, 1 short, 2 group, 3 none |
| addr_wr_data | input | 16 | Value to load (low 8 bits for short and group) |
| cmd_o | output | 8 | Command byte of the accepted frame |
| cmd_valid | output | 1 | cmd_o valid, one cycle |
| data_o | output | 8 | Released payload byte |
| data_valid | output | 1 | data_o valid |
| msg_accept | output | 1 | Frame accepted, one-cycle pulse |
| frame_err | output | 1 | Length or checksum error, one-cycle pulse |

## Verification
The hardest case to reach is a frame whose checksum is right but whose destination falls in the reserved top page and collides with a register's contents. An example is 0xFF00 arriving at a station whose main register also holds 0xFF00: this frame must be dropped, whereas 0xFEFF must be accepted. The stimulus reaches these cases from reset values alone, then reprograms the three registers through the write port. It replays the same destinations so that each range is seen both matching and missing. Bad lengths, 0 and 18 payload bytes, corrupted checksums and marker-free garbage are sent between good frames, so that the parser is also shown to recover.

// File: rtl/msg_frame_pkg.sv
package msg_frame_pkg;

  localparam logic [7:0]  SOF_BYTE    = 8'hA5;
  localparam logic [7:0]  PFX_SHORT   = 8'hFC;
  localparam logic [7:0]  PFX_GROUP   = 8'hFD;
  localparam logic [7:0]  PFX_MAIN_HI = 8'hFE;
  localparam logic [7:0]  PFX_BCAST   = 8'hFF;
  localparam logic [7:0]  BC_MASKABLE = 8'hFE;
  localparam logic [7:0]  BC_ALWAYS   = 8'hFF;
  localparam logic [15:0] MAIN_RST    = 16'hFF00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_BODY  = 2'd2,
    ST_REL   = 2'd3
  } prs_state_e;

  typedef enum logic [1:0] {
    SEL_MAIN  = 2'd0,
    SEL_SHORT = 2'd1,
    SEL_GROUP = 2'd2,
    SEL_NONE  = 2'd3
  } id_sel_e;

endpackage

// File: rtl/msg_addr_match.sv
module msg_addr_match
  import msg_frame_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic [2*BW-1:0] dest,
  input  logic [2*BW-1:0] main_id,
  input  logic [BW-1:0]   short_id,
  input  logic [BW-1:0]   group_id,
  input  logic            bcast_mask,
  output logic            hit
);
  logic [BW-1:0] pg;
  logic [BW-1:0] off;

  assign pg  = dest[2*BW-1:BW];
  assign off = dest[BW-1:0];

  always_comb begin
    hit = 1'b0;
    if (pg < PFX_SHORT)        hit = (dest == main_id);
    else if (pg == PFX_SHORT)  hit = (off == short_id);
    else if (pg == PFX_GROUP)  hit = (off == group_id);
    else if (pg == PFX_MAIN_HI) hit = (off == main_id[2*BW-1:BW]);
    else if (off == BC_ALWAYS) hit = 1'b1;
    else if (off == BC_MASKABLE) hit = !bcast_mask;
    else                       hit = 1'b0;
  end
endmodule

// File: rtl/msg_payload_buf.sv
module msg_payload_buf #(
  parameter int DEPTH = 18,
  parameter int BW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [BW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [BW-1:0] rdata
);
  logic [BW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (waddr == IW'(g))) mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr == IW'(i)) rdata = mem[i];
    end
  end
endmodule

// File: rtl/msg_frame_filter.sv
module msg_frame_filter
  import msg_frame_pkg::*;
#(
  parameter int MAX_DATA = 18,
  parameter int BW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  input  logic          bcast_mask,
  input  logic          addr_wr_en,
  input  logic [1:0]    addr_wr_sel,
  input  logic [15:0]   addr_wr_data,
  output logic [7:0]    cmd_o,
  output logic          cmd_valid,
  output logic [7:0]    data_o,
  output logic          data_valid,
  output logic          msg_accept,
  output logic          frame_err
);
  localparam int MIN_CNT = 4;
  localparam int MAX_CNT = MAX_DATA + MIN_CNT;
  localparam int IW      = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1;
  localparam int NW      = $clog2(MAX_DATA + 1);
  localparam int CW      = $clog2(MAX_CNT + 1);
  localparam int AW      = 2 * BW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  prs_state_e    state_q, state_d;
  logic [BW-1:0] rem_q, rem_d;
  logic [CW-1:0] pos_q, pos_d;
  logic [BW-1:0] sum_q, sum_d;
  logic [AW-1:0] dest_q, dest_d;
  logic [BW-1:0] cmd_q, cmd_d;
  logic [NW-1:0] ndata_q, ndata_d;
  logic [NW-1:0] rd_q, rd_d;
  logic [BW-1:0] cmd_o_d, data_o_d;
  logic          cmdv_d, dv_d, acc_d, err_d;

  logic [AW-1:0] main_id;
  logic [BW-1:0] short_id, group_id;

  logic          addr_hit;
  logic          buf_we;
  logic [IW-1:0] buf_waddr, buf_raddr;
  logic [BW-1:0] buf_rdata;

  msg_addr_match #(.BW(BW)) u_match (
    .dest       (dest_q),
    .main_id    (main_id),
    .short_id   (short_id),
    .group_id   (group_id),
    .bcast_mask (bcast_mask),
    .hit        (addr_hit)
  );

  msg_payload_buf #(.DEPTH(MAX_DATA), .BW(BW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (rx_byte),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  assign buf_waddr = IW'(pos_q - CW'(3));
  assign buf_raddr = IW'(rd_q);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    pos_d    = pos_q;
    sum_d    = sum_q;
    dest_d   = dest_q;
    cmd_d    = cmd_q;
    ndata_d  = ndata_q;
    rd_d     = rd_q;
    cmd_o_d  = cmd_o;
    data_o_d = data_o;
    cmdv_d   = 1'b0;
    dv_d     = 1'b0;
    acc_d    = 1'b0;
    err_d    = 1'b0;
    buf_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_valid && (rx_byte == SOF_BYTE)) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (rx_valid) begin
          if ((rx_byte < BW'(MIN_CNT)) || (rx_byte > BW'(MAX_CNT))) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            sum_d   = rx_byte;
            rem_d   = rx_byte;
            pos_d   = '0;
            ndata_d = NW'(rx_byte - BW'(MIN_CNT));
            state_d = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        if (rx_valid) begin
          if (rem_q == BW'(1)) begin
            rd_d = '0;
            if (rx_byte != sum_q) begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end else if (addr_hit) begin
              acc_d   = 1'b1;
              cmdv_d  = 1'b1;
              cmd_o_d = cmd_q;
              state_d = (ndata_q != '0) ? ST_REL : ST_IDLE;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            sum_d = sum_q + rx_byte;
            rem_d = rem_q - BW'(1);
            pos_d = pos_q + CW'(1);
            if (pos_q == CW'(0))      dest_d[AW-1:BW] = rx_byte;
            else if (pos_q == CW'(1)) dest_d[BW-1:0]  = rx_byte;
            else if (pos_q == CW'(2)) cmd_d           = rx_byte;
            else                      buf_we          = 1'b1;
          end
        end
      end
      ST_REL: begin
        dv_d     = 1'b1;
        data_o_d = buf_rdata;
        rd_d     = rd_q + NW'(1);
        if (rd_q == (ndata_q - NW'(1))) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      pos_q      <= '0;
      sum_q      <= '0;
      dest_q     <= '0;
      cmd_q      <= '0;
      ndata_q    <= '0;
      rd_q       <= '0;
      cmd_o      <= '0;
      data_o     <= '0;
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      msg_accept <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      state_q    <= state_d;
      rem_q      <= rem_d;
      pos_q      <= pos_d;
      sum_q      <= sum_d;
      dest_q     <= dest_d;
      cmd_q      <= cmd_d;
      ndata_q    <= ndata_d;
      rd_q       <= rd_d;
      cmd_o      <= cmd_o_d;
      data_o     <= data_o_d;
      cmd_valid  <= cmdv_d;
      data_valid <= dv_d;
      msg_accept <= acc_d;
      frame_err  <= err_d;
    end
  end

  // station identity registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      main_id  <= MAIN_RST;
      short_id <= '0;
      group_id <= '0;
    end else if (addr_wr_en) begin
      if (addr_wr_sel == SEL_MAIN)  main_id  <= addr_wr_data;
      if (addr_wr_sel == SEL_SHORT) short_id <= addr_wr_data[BW-1:0];
      if (addr_wr_sel == SEL_GROUP) group_id <= addr_wr_data[BW-1:0];
    end
  end

  // assertions
  p_no_accept_with_err_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(msg_accept && frame_err));

  p_accept_single_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msg_accept |=> !msg_accept);

  p_data_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(data_valid) |-> $past(msg_accept));

  p_ffpage_reserved_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dest_q[AW-1:BW] == PFX_BCAST) && (dest_q[BW-1:1] != {(BW-1){1'b1}})) |-> !addr_hit);

  p_err_single_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_err |=> !frame_err);

  p_err_origin_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_err |-> ($past(state_q) == ST_COUNT || $past(state_q) == ST_BODY));

endmodule

// File: tb/msg_frame_filter_bench.sv
module msg_frame_filter_bench;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  cmd;
    logic [4:0]  n;
    logic        bad;
    logic        mask;
    logic        exp_acc;
    logic        exp_err;
  } vec_t;

  // vectors run from reset values: main=FF00, short=00, group=00
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'hFEFF, 8'h11, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0},  // R6 R8
    '{16'hFC00, 8'h22, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0},  // R5 R8
    '{16'hFD00, 8'h33, 5'd18, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 R8 R10
    '{16'hFFFF, 8'h44, 5'd2,  1'b0, 1'b1, 1'b1, 1'b0},  // R7
    '{16'hFFFE, 8'h55, 5'd2,  1'b0, 1'b1, 1'b0, 1'b0},  // R7
    '{16'hFFFE, 8'h66, 5'd1,  1'b0, 1'b0, 1'b1, 1'b0},  // R7
    '{16'hFFFD, 8'h77, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0},  // R7
    '{16'hFF00, 8'h88, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0},  // R7 R4
    '{16'h1234, 8'h99, 5'd4,  1'b0, 1'b0, 1'b0, 1'b0},  // R4 R9
    '{16'hFEFF, 8'hAA, 5'd5,  1'b1, 1'b0, 1'b0, 1'b1},  // R3
    '{16'hFC01, 8'hBB, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0}   // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        bcast_mask = 1'b0;
  logic        addr_wr_en = 1'b0;
  logic [1:0]  addr_wr_sel = '0;
  logic [15:0] addr_wr_data = '0;
  logic [7:0]  cmd_o, data_o;
  logic        cmd_valid, data_valid, msg_accept, frame_err;

  msg_frame_filter u_msg_frame_filter (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .bcast_mask(bcast_mask), .addr_wr_en(addr_wr_en), .addr_wr_sel(addr_wr_sel),
    .addr_wr_data(addr_wr_data), .cmd_o(cmd_o), .cmd_valid(cmd_valid),
    .data_o(data_o), .data_valid(data_valid), .msg_accept(msg_accept),
    .frame_err(frame_err)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int failures = 0;

  // monitor: running totals only
  logic [7:0]  cap [256];
  int unsigned cap_n = 0, acc_n = 0, err_n = 0;
  logic [7:0]  last_cmd = '0;
  always @(negedge clk) begin
    if (data_valid) begin
      cap[cap_n % 256] <= data_o;
      cap_n <= cap_n + 1;
    end
    if (msg_accept) acc_n <= acc_n + 1;
    if (frame_err)  err_n <= err_n + 1;
    if (cmd_valid)  last_cmd <= cmd_o;
  end

  logic smp_acc, smp_err, smp_cmdv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    smp_acc  = msg_accept;
    smp_err  = frame_err;
    smp_cmdv = cmd_valid;
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pay(input logic [7:0] cmd, input int i);
    return cmd + 8'(i * 29) + 8'h05;
  endfunction

  task automatic wr_id(input logic [1:0] sel, input logic [15:0] val);
    addr_wr_en   = 1'b1;
    addr_wr_sel  = sel;
    addr_wr_data = val;
    @(negedge clk);
    addr_wr_en   = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input string tag, input logic [15:0] addr, input logic [7:0] cmd,
                           input int n, input logic bad, input logic mask,
                           input logic exp_acc, input logic exp_err);
    int unsigned a0, e0, c0;
    logic [7:0] cnt, sum;
    int mism;
    bcast_mask = mask;
    a0 = acc_n; e0 = err_n; c0 = cap_n;
    cnt = 8'(n + 4);
    sum = cnt + addr[15:8] + addr[7:0] + cmd;
    send_byte(8'hA5);
    send_byte(cnt);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    send_byte(cmd);
    for (int i = 0; i < n; i++) begin
      send_byte(pay(cmd, i));
      sum = sum + pay(cmd, i);
    end
    send_byte(bad ? sum + 8'h01 : sum);
    // pulse seen in the cycle right after the checksum byte (R10, R12)
    chk({tag, " R10 accept timing"}, {31'd0, smp_acc & smp_cmdv}, {31'd0, exp_acc});
    chk({tag, " R12 err timing"}, {31'd0, smp_err}, {31'd0, exp_err});
    repeat (24) @(negedge clk);
    chk({tag, " accept count"}, acc_n - a0, {31'd0, exp_acc});
    chk({tag, " error count"}, err_n - e0, {31'd0, exp_err});
    if (exp_acc) begin
      chk({tag, " R10 cmd"}, {24'd0, last_cmd}, {24'd0, cmd});
      chk({tag, " R10 data length"}, cap_n - c0, n);
      mism = 0;
      for (int i = 0; i < n; i++)
        if (cap[(c0 + i) % 256] !== pay(cmd, i)) mism++;
      chk({tag, " R10 data order"}, mism, 0);
    end else begin
      chk({tag, " R9 no data"}, cap_n - c0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    int unsigned a0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 reset outputs", {28'd0, msg_accept, frame_err, cmd_valid, data_valid}, 32'd0);

    for (int v = 0; v < NV; v++)
      run_frame($sformatf("vec%0d", v), VEC[v].addr, VEC[v].cmd, int'(VEC[v].n),
                VEC[v].bad, VEC[v].mask, VEC[v].exp_acc, VEC[v].exp_err);

    // R1: garbage while idle
    a0 = acc_n; e0 = err_n;
    send_byte(8'h00); send_byte(8'h05); send_byte(8'hFF); send_byte(8'h5A);
    repeat (4) @(negedge clk);
    chk("R1 garbage ignored", (acc_n - a0) + (err_n - e0) + {31'd0, data_valid}, 0);
    run_frame("R1 frame after garbage", 16'hFEFF, 8'h01, 2, 1'b0, 1'b0, 1'b1, 1'b0);

    // R2: length window
    e0 = err_n;
    send_byte(8'hA5); send_byte(8'd3);
    chk("R2 length 3 err", {31'd0, smp_err}, 32'd1);
    send_byte(8'hA5); send_byte(8'd23);
    chk("R2 length 23 err", {31'd0, smp_err}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R2 err count", err_n - e0, 2);
    run_frame("R2 length 4", 16'hFFFF, 8'h02, 0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R11: program identities
    wr_id(2'd0, 16'h1234);
    wr_id(2'd1, 16'h775A);
    wr_id(2'd2, 16'h66C3);
    run_frame("R4 main hit", 16'h1234, 8'h10, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R4 main miss", 16'h1235, 8'h11, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame("R6 upper hit", 16'hFE12, 8'h12, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R6 old default miss", 16'hFEFF, 8'h13, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame("R5 short hit", 16'hFC5A, 8'h14, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R5 group hit", 16'hFDC3, 8'h15, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R5 group miss", 16'hFD00, 8'h16, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_id(2'd3, 16'h0000);
    run_frame("R11 sel3 group kept", 16'hFDC3, 8'h17, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R11 sel3 main kept", 16'h1234, 8'h18, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R11 sel3 short kept", 16'hFC5A, 8'h19, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    wr_id(2'd0, 16'hFBFF);
    run_frame("R4 top of direct range", 16'hFBFF, 8'h1A, 18, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R3 bad sum max len", 16'hFBFF, 8'h1B, 18, 1'b1, 1'b0, 1'b0, 1'b1);

    report();
    $finish;
  end

endmodule